// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Slave

This block is the device side of a small serial nonvolatile memory reached over a three-wire link: a select line, a shift clock and a serial data input, with a serial data output and its output enable going back to the host. The select, shift clock and data lines are sampled into the system clock domain and edge-detected. Every transfer opens with a rising select edge. The block then skips zeros until it sees a start bit of 1, reads a two-bit opcode, and then reads an address field whose width depends on the organization strap. The storage is a register array inside the block. It is treated as bytes, so the strap picks between byte-wide words and 16-bit words over the same storage.

Reads stream out with no limit. A single zero comes first, then the data, and the address pointer steps on to the next word for as long as select stays high. Programming commands (word write, word erase, fill of the whole array, clear of the whole array) are accepted only after the enable command has armed a latch, which is disarmed at reset and by the disable command. Each accepted programming command starts a self-timed cycle, modelled by a counter of system clock cycles. When select is raised while that cycle is running, the data output reports busy or ready.

Top module: `serial_nvm_slave`

## Requirements
- R1: A transfer begins at a rising select edge. Data-in is sampled at each rising shift-clock edge, and zero bits before the first 1 are skipped. The 1 is the start bit. After it come two opcode bits and then the address field, all most significant bit first.
- R2: With the strap low, each word is 8 bits and the address is 9 bits. With the strap high, each word is 16 bits and the address is 8 bits; word w holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8. The strap is taken at the start bit.
- R3: Opcode 10 reads. After the last address bit the output drives a single 0. After each following rising shift-clock edge it drives the next data bit, most significant first. This works whether the enable latch is armed or not.
- R4: While select stays high, a read continues with the next word and no zero between words. The address wraps from the last word to word 0.
- R5: Opcode 00 selects a command from the top two address bits: 11 arms the enable latch, 00 disarms it, 10 clears the whole array and 01 fills it. The latch is disarmed after reset. While it is disarmed, every programming command leaves the array unchanged.
- R6: Opcode 01 writes the addressed word with the data bits that follow the address. Opcode 11 sets the addressed word to all ones. A write needs no prior erase.
- R7: The fill command writes the data word that follows the address field into every word. The clear command sets every bit of the array to 1.
- R8: A self-timed cycle of PROG_CYCLES system clocks starts once the last bit of an accepted programming command has been received.
- R9: If select rises while the self-timed cycle runs, the output is enabled and drives 0 while busy and 1 once done, until select falls.
- R10: If select rises after the self-timed cycle has ended, no status is driven and the output stays disabled while the next instruction is shifted in.
- R11: The output enable is low while select is low and while an instruction is being shifted in.
- R12: If select falls before an instruction is complete, the array and the enable latch are left unchanged.
- R13: After reset every array bit is 1, the latch is disarmed and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Select line, high while a transfer is in progress |
| sclk_i | input | 1 | Serial shift clock from the host |
| sdi_i | input | 1 | Serial data in |
| org_wide_i | input | 1 | Organization strap: 1 selects 16-bit words, 0 selects bytes |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
Reads and writes at random addresses with random data are run in both organizations. Word writes are read back byte by byte, which tells the lane order apart from a swapped or truncated write. Streaming reads that start at the last word separate a correct wrap and the absence of a zero between words from a pointer that stalls or leaves a gap. Directed sequences arm and disarm the latch, abort a write and a disable command halfway through, and raise select during, and only after, the self-timed cycle. These show whether the ignore, abort and status rules are each honoured on their own.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_HUNT, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_STAT, ST_HOLD
   } nvm_state_e;

   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_ERASE = 2'b11
   } nvm_op_e;

   typedef enum logic [1:0] {
      EX_DIS   = 2'b00,
      EX_FILL  = 2'b01,
      EX_CLEAR = 2'b10,
      EX_EN    = 2'b11
   } nvm_ext_e;

   typedef enum logic [2:0] {
      PG_NONE, PG_WORD, PG_ERASE, PG_FILL, PG_CLEAR
   } prog_kind_e;
endpackage

// File: rtl/nvm_pin_sync.sv
module nvm_pin_sync #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pins_i,
   output logic [N-1:0] level_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nvm_pin_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe_q <= '0;
         else        pipe_q <= {pipe_q[STAGES-2:0], pins_i[g]};
      end
      assign level_o[g] = pipe_q[STAGES-1];
   end
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
   parameter int CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("nvm_prog_timer: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (start_i)          cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)      cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);

   assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
endmodule

// File: rtl/nvm_store.sv
module nvm_store
   import nvm_pkg::*;
#(
   parameter int ABYTE_W = 9,
   parameter int BYTE_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wide_i,
   input  logic [ABYTE_W-1:0]    rd_addr_i,
   output logic [2*BYTE_W-1:0]   rd_data_o,
   input  prog_kind_e            kind_i,
   input  logic [ABYTE_W-1:0]    wr_addr_i,
   input  logic [2*BYTE_W-1:0]   wr_data_i
);
   localparam int DEPTH = 1 << ABYTE_W;

   if (ABYTE_W < 3) begin : g_bad_addr
      $error("nvm_store: ABYTE_W must be at least 3");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("nvm_store: BYTE_W must be at least 1");
   end

   logic [BYTE_W-1:0] cell_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [ABYTE_W-1:0] BIDX = ABYTE_W'(i);
      logic              hit;
      logic [BYTE_W-1:0] lane;
      logic [BYTE_W-1:0] byte_q;

      always_comb begin
         hit  = wide_i ? (wr_addr_i[ABYTE_W-2:0] == BIDX[ABYTE_W-1:1])
                       : (wr_addr_i == BIDX);
         lane = (wide_i && BIDX[0]) ? wr_data_i[2*BYTE_W-1:BYTE_W]
                                    : wr_data_i[BYTE_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) byte_q <= '1;
         else begin
            case (kind_i)
               PG_WORD:  if (hit) byte_q <= lane;
               PG_ERASE: if (hit) byte_q <= '1;
               PG_FILL:  byte_q <= lane;
               PG_CLEAR: byte_q <= '1;
               default:  ;
            endcase
         end
      end

      assign cell_w[i] = byte_q;
   end

   logic [ABYTE_W-1:0] lo_idx;
   logic [ABYTE_W-1:0] hi_idx;

   assign lo_idx    = wide_i ? {rd_addr_i[ABYTE_W-2:0], 1'b0} : rd_addr_i;
   assign hi_idx    = {rd_addr_i[ABYTE_W-2:0], 1'b1};
   assign rd_data_o = wide_i ? {cell_w[hi_idx], cell_w[lo_idx]}
                             : {{BYTE_W{1'b0}}, cell_w[lo_idx]};
endmodule

// File: rtl/nvm_cmd_engine.sv
module nvm_cmd_engine
   import nvm_pkg::*;
#(
   parameter int ABYTE_W = 9,
   parameter int BYTE_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_i,
   input  logic                sk_i,
   input  logic                di_i,
   input  logic                org_wide_i,
   input  logic                busy_i,
   input  logic [2*BYTE_W-1:0] rd_data_i,
   output logic                wide_o,
   output logic [ABYTE_W-1:0]  rd_addr_o,
   output prog_kind_e          prog_kind_o,
   output logic [ABYTE_W-1:0]  prog_addr_o,
   output logic [2*BYTE_W-1:0] prog_data_o,
   output logic                sdo_o,
   output logic                sdo_oe_o
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int CNT_W  = $clog2(WORD_W + ABYTE_W + 1);
   localparam int IDX_W  = $clog2(WORD_W);

   nvm_state_e          state_q;
   prog_kind_e          kind_q;
   logic                cs_prev_q, sk_prev_q;
   logic                org_q, en_q, sdo_q, oe_q;
   logic [1:0]          op_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [ABYTE_W-1:0]  addr_sr_q, ptr_q, paddr_q;
   logic [WORD_W-1:0]   data_sr_q, pdata_q;

   logic                cs_rise, cs_fall, sk_rise, last;
   logic [ABYTE_W-1:0]  addr_next, addr_mask, addr_fld;
   logic [WORD_W-1:0]   data_next, data_fld;
   logic [1:0]          ext_code;
   logic [CNT_W-1:0]    aw_len, dw_len;
   logic [IDX_W-1:0]    bit_idx;

   always_comb begin
      cs_rise   = cs_i & ~cs_prev_q;
      cs_fall   = ~cs_i & cs_prev_q;
      sk_rise   = sk_i & ~sk_prev_q;
      last      = (cnt_q == CNT_W'(1));
      addr_next = {addr_sr_q[ABYTE_W-2:0], di_i};
      addr_mask = org_q ? {1'b0, {(ABYTE_W-1){1'b1}}} : {ABYTE_W{1'b1}};
      addr_fld  = addr_next & addr_mask;
      ext_code  = org_q ? addr_next[ABYTE_W-2 -: 2] : addr_next[ABYTE_W-1 -: 2];
      data_next = {data_sr_q[WORD_W-2:0], di_i};
      data_fld  = org_q ? data_next : {{BYTE_W{1'b0}}, data_next[BYTE_W-1:0]};
      aw_len    = org_q ? CNT_W'(ABYTE_W - 1) : CNT_W'(ABYTE_W);
      dw_len    = org_q ? CNT_W'(WORD_W) : CNT_W'(BYTE_W);
      bit_idx   = IDX_W'(cnt_q - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         kind_q    <= PG_NONE;
         cs_prev_q <= 1'b0;
         sk_prev_q <= 1'b0;
         org_q     <= 1'b0;
         en_q      <= 1'b0;
         sdo_q     <= 1'b0;
         oe_q      <= 1'b0;
         op_q      <= 2'b00;
         cnt_q     <= '0;
         addr_sr_q <= '0;
         ptr_q     <= '0;
         paddr_q   <= '0;
         data_sr_q <= '0;
         pdata_q   <= '0;
      end else begin
         cs_prev_q <= cs_i;
         sk_prev_q <= sk_i;
         kind_q    <= PG_NONE;
         if (cs_fall) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
            sdo_q   <= 1'b0;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (cs_rise) begin
                     if (busy_i) begin
                        state_q <= ST_STAT;
                        oe_q    <= 1'b1;
                        sdo_q   <= 1'b0;
                     end else begin
                        state_q <= ST_HUNT;
                     end
                  end
               end
               ST_HUNT: begin
                  if (sk_rise && di_i) begin
                     state_q   <= ST_OPC;
                     org_q     <= org_wide_i;
                     cnt_q     <= CNT_W'(2);
                     addr_sr_q <= '0;
                     data_sr_q <= '0;
                  end
               end
               ST_OPC: begin
                  if (sk_rise) begin
                     op_q <= {op_q[0], di_i};
                     if (last) begin
                        state_q <= ST_ADDR;
                        cnt_q   <= aw_len;
                     end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                     end
                  end
               end
               ST_ADDR: begin
                  if (sk_rise) begin
                     addr_sr_q <= addr_next;
                     if (!last) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                     end else begin
                        state_q <= ST_HOLD;
                        case (nvm_op_e'(op_q))
                           OP_READ: begin
                              state_q <= ST_READ;
                              ptr_q   <= addr_fld;
                              cnt_q   <= dw_len;
                              oe_q    <= 1'b1;
                              sdo_q   <= 1'b0;
                           end
                           OP_WRITE: begin
                              state_q <= ST_DATA;
                              cnt_q   <= dw_len;
                              paddr_q <= addr_fld;
                           end
                           OP_ERASE: begin
                              if (en_q && !busy_i) begin
                                 kind_q  <= PG_ERASE;
                                 paddr_q <= addr_fld;
                              end
                           end
                           default: begin
                              case (nvm_ext_e'(ext_code))
                                 EX_EN:    en_q <= 1'b1;
                                 EX_DIS:   en_q <= 1'b0;
                                 EX_CLEAR: if (en_q && !busy_i) kind_q <= PG_CLEAR;
                                 default: begin
                                    state_q <= ST_DATA;
                                    cnt_q   <= dw_len;
                                 end
                              endcase
                           end
                        endcase
                     end
                  end
               end
               ST_DATA: begin
                  if (sk_rise) begin
                     data_sr_q <= data_next;
                     if (!last) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                     end else begin
                        state_q <= ST_HOLD;
                        if (en_q && !busy_i) begin
                           kind_q  <= (op_q == OP_WRITE) ? PG_WORD : PG_FILL;
                           pdata_q <= data_fld;
                        end
                     end
                  end
               end
               ST_READ: begin
                  if (sk_rise) begin
                     sdo_q <= rd_data_i[bit_idx];
                     if (last) begin
                        ptr_q <= (ptr_q + ABYTE_W'(1)) & addr_mask;
                        cnt_q <= dw_len;
                     end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                     end
                  end
               end
               ST_STAT: sdo_q <= ~busy_i;
               ST_HOLD: ;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign wide_o      = org_q;
   assign rd_addr_o   = ptr_q;
   assign prog_kind_o = kind_q;
   assign prog_addr_o = paddr_q;
   assign prog_data_o = pdata_q;
   assign sdo_o       = sdo_q;
   assign sdo_oe_o    = oe_q;

   assert_dummy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == ST_READ) |-> (oe_q && !sdo_q));

   assert_prog_needs_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q != PG_NONE) |-> en_q);

   assert_status_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STAT && $past(state_q == ST_STAT) && !$past(busy_i)) |-> (sdo_q && oe_q));

   assert_fall_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> !oe_q);
endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave
   import nvm_pkg::*;
#(
   parameter int ABYTE_W     = 9,
   parameter int BYTE_W      = 8,
   parameter int PROG_CYCLES = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_i,
   input  logic sclk_i,
   input  logic sdi_i,
   input  logic org_wide_i,
   output logic sdo_o,
   output logic sdo_oe_o
);
   localparam int WORD_W = 2 * BYTE_W;

   logic [2:0]         pin_lvl;
   logic               busy_w, wide_w;
   logic [ABYTE_W-1:0] rd_addr_w, prog_addr_w;
   logic [WORD_W-1:0]  rd_data_w, prog_data_w;
   prog_kind_e         prog_kind_w;

   nvm_pin_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  ({sdi_i, sclk_i, sel_i}),
      .level_o (pin_lvl)
   );

   nvm_cmd_engine #(.ABYTE_W(ABYTE_W), .BYTE_W(BYTE_W)) engine_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_i        (pin_lvl[0]),
      .sk_i        (pin_lvl[1]),
      .di_i        (pin_lvl[2]),
      .org_wide_i  (org_wide_i),
      .busy_i      (busy_w),
      .rd_data_i   (rd_data_w),
      .wide_o      (wide_w),
      .rd_addr_o   (rd_addr_w),
      .prog_kind_o (prog_kind_w),
      .prog_addr_o (prog_addr_w),
      .prog_data_o (prog_data_w),
      .sdo_o       (sdo_o),
      .sdo_oe_o    (sdo_oe_o)
   );

   nvm_store #(.ABYTE_W(ABYTE_W), .BYTE_W(BYTE_W)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_i    (wide_w),
      .rd_addr_i (rd_addr_w),
      .rd_data_o (rd_data_w),
      .kind_i    (prog_kind_w),
      .wr_addr_i (prog_addr_w),
      .wr_data_i (prog_data_w)
   );

   nvm_prog_timer #(.CYCLES(PROG_CYCLES)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (prog_kind_w != PG_NONE),
      .busy_o  (busy_w)
   );

   assert_quiet_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_lvl[0] |=> !sdo_oe_o);

   assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_kind_w != PG_NONE) |-> !busy_w);
endmodule

// File: tb/serial_nvm_slave_tb_top.sv
module serial_nvm_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int PROG       = 200;
   localparam int ABW        = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b0;
   logic sdo, sdo_oe;
   int   n_checks = 0, n_fail = 0;
   logic [7:0] mdl [512];
   bit   en_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_nvm_slave #(.ABYTE_W(ABW), .BYTE_W(8), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
      .org_wide_i(org), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic b);
      sdi = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
   endtask

   task automatic shove(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) pulse(v[i]);
   endtask

   task automatic sel_on();
      sel = 1'b1; tick(HALF);
   endtask

   task automatic sel_off();
      sel = 1'b0; sdi = 1'b0; tick(2 * HALF);
   endtask

   function automatic int aw(input bit w); return w ? ABW - 1 : ABW; endfunction
   function automatic int dw(input bit w); return w ? 16 : 8; endfunction
   function automatic int depth(input bit w); return w ? 256 : 512; endfunction

   function automatic logic [15:0] mword(input bit w, input int a);
      return w ? {mdl[2*a+1], mdl[2*a]} : {8'h00, mdl[a]};
   endfunction

   task automatic mput(input bit w, input int a, input logic [15:0] d);
      if (w) begin mdl[2*a] = d[7:0]; mdl[2*a+1] = d[15:8]; end
      else mdl[a] = d[7:0];
   endtask

   task automatic mfill(input bit w, input logic [15:0] d);
      for (int a = 0; a < depth(w); a++) mput(w, a, d);
   endtask

   task automatic op_ext(input bit w, input logic [1:0] code);
      org = w; sel_on(); shove(32'b100, 3); shove(32'(code), 2); shove(0, aw(w) - 2); sel_off();
      if (code == 2'b11) en_m = 1'b1;
      else if (code == 2'b00) en_m = 1'b0;
      else if (en_m) mfill(1'b0, 16'h00ff);
      tick(PROG + 60);
   endtask

   task automatic op_fill(input bit w, input logic [15:0] d);
      org = w; sel_on(); shove(32'b100, 3); shove(32'b01, 2); shove(0, aw(w) - 2);
      shove(32'(d), dw(w)); sel_off();
      if (en_m) mfill(w, d);
      tick(PROG + 60);
   endtask

   task automatic op_write(input bit w, input int a, input logic [15:0] d);
      org = w; sel_on(); shove(32'b101, 3); shove(a, aw(w)); shove(32'(d), dw(w)); sel_off();
      if (en_m) mput(w, a, d);
      tick(PROG + 60);
   endtask

   task automatic op_erase(input bit w, input int a);
      org = w; sel_on(); shove(32'b111, 3); shove(a, aw(w)); sel_off();
      if (en_m) mput(w, a, 16'hffff);
      tick(PROG + 60);
   endtask

   task automatic read_check(input string req, input bit w, input int a, input int n, input int lead);
      logic [15:0] got;
      org = w; sel_on();
      shove(0, lead);
      shove(32'b110, 3); shove(a, aw(w));
      chk_eq({req, " R3 dummy enable"}, 32'(sdo_oe), 1);
      chk_eq({req, " R3 dummy zero"}, 32'(sdo), 0);
      for (int k = 0; k < n; k++) begin
         got = '0;
         for (int i = 0; i < dw(w); i++) begin
            pulse(1'b0);
            got = {got[14:0], sdo};
         end
         chk_eq(req, 32'(got), 32'(mword(w, (a + k) % depth(w))));
      end
      sel_off();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      int a;
      logic [15:0] d;
      seed_init = $urandom(32'd20240611);
      for (int i = 0; i < 512; i++) mdl[i] = 8'hff;

      tick(5); rst_n = 1'b1; tick(5);
      chk_eq("R13 enable low after reset", 32'(sdo_oe), 0);
      read_check("R13 array ones after reset", 1'b0, 0, 1, 0);

      // R5: disarmed latch ignores programming, read still works
      op_write(1'b0, 5, 16'h003c);
      read_check("R5 write ignored when disarmed", 1'b0, 5, 1, 0);

      op_ext(1'b0, 2'b11);
      // R6 / R2: random byte-mode writes
      for (int k = 0; k < 8; k++) begin
         a = int'($urandom % 512); d = 16'($urandom);
         op_write(1'b0, a, d);
         read_check("R6 byte write readback", 1'b0, a, 1, 0);
      end
      // R2: random word-mode writes, checked as words and as bytes
      for (int k = 0; k < 6; k++) begin
         a = int'($urandom % 256); d = 16'($urandom);
         op_write(1'b1, a, d);
         read_check("R2 word write readback", 1'b1, a, 1, 0);
         read_check("R2 byte lanes of word", 1'b0, 2 * a, 2, 0);
      end

      // R4: streaming with wrap, both organizations
      read_check("R4 word stream wrap", 1'b1, 255, 3, 0);
      read_check("R4 byte stream wrap", 1'b0, 510, 4, 0);

      // R1: leading zeros before the start bit
      read_check("R1 leading zeros skipped", 1'b0, 17, 1, 3);

      // R6: erase a word
      op_write(1'b1, 40, 16'h1234);
      op_erase(1'b1, 40);
      read_check("R6 erase sets ones", 1'b1, 40, 1, 0);

      // R8 / R9 / R11: status during self-timed cycle
      org = 1'b0; sel_on(); shove(32'b101, 3); shove(77, 9);
      chk_eq("R11 enable low during shift-in", 32'(sdo_oe), 0);
      shove(32'h5a, 8); mput(1'b0, 77, 16'h005a);
      sel = 1'b0; tick(4);
      chk_eq("R11 enable low with select low", 32'(sdo_oe), 0);
      sel = 1'b1; tick(10);
      chk_eq("R9 status enabled", 32'(sdo_oe), 1);
      chk_eq("R9 busy drives zero", 32'(sdo), 0);
      tick(PROG - 100);
      chk_eq("R8 still busy before cycle end", 32'(sdo), 0);
      tick(120);
      chk_eq("R8 ready after cycle end", 32'(sdo), 1);
      chk_eq("R9 status held while select high", 32'(sdo_oe), 1);
      sel_off();
      read_check("R6 write with status poll", 1'b0, 77, 1, 0);

      // R10: select raised after cycle finished drives nothing
      op_write(1'b0, 78, 16'h00c3);
      sel_on(); tick(6);
      chk_eq("R10 no status after cycle", 32'(sdo_oe), 0);
      sel_off();

      // R12: aborted write leaves array unchanged
      org = 1'b0; sel_on(); shove(32'b101, 3); shove(78, 9); shove(32'h9, 4); sel_off();
      tick(PROG + 60);
      read_check("R12 aborted write", 1'b0, 78, 1, 0);
      // R12: aborted disable leaves latch armed
      org = 1'b0; sel_on(); shove(32'b100, 3); shove(0, 4); sel_off();
      op_write(1'b0, 79, 16'h0011);
      read_check("R12 latch kept after aborted disable", 1'b0, 79, 1, 0);

      // R7: fill and clear
      op_fill(1'b0, 16'h00a5);
      read_check("R7 byte fill", 1'b0, int'($urandom % 512), 1, 0);
      op_ext(1'b0, 2'b10);
      read_check("R7 clear all", 1'b0, int'($urandom % 512), 2, 0);
      op_fill(1'b1, 16'h1234);
      read_check("R7 word fill low lane", 1'b0, 100, 2, 0);

      // R5: disarm, programming ignored, read still works
      op_ext(1'b1, 2'b00);
      op_write(1'b0, 100, 16'h0000);
      op_erase(1'b1, 51);
      op_ext(1'b0, 2'b10);
      read_check("R5 disarmed write ignored", 1'b0, 100, 1, 0);
      read_check("R5 disarmed erase ignored", 1'b1, 51, 1, 0);

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule